// File: doc/BRIEF.md
# Receiver Polling-Mode Sequencer

This block duty-cycles a low-power radio receiver. Most of the time the receiver sleeps with its signal path switched off and only a timer running. At the end of each sleep interval the block powers up the signal path, waits for the front end to settle, and then asks an external bit checker whether a valid transmitter is on the air. A passing check keeps the receiver on. A failing check sends it back to sleep for another interval.

The sleep interval is the product of a 5-bit sleep word, an extension factor and a fixed unit of 1024 basic clock periods. Each rising edge of `clk` is one basic clock period. The settle time comes from a four-entry table that a 2-bit baud-range selection indexes. The bit checker is modelled as a handshake: the block sends a start strobe, and the checker answers with a done flag and a pass flag. An OFF command ends any active phase and returns the block to sleep.

Top module: `rx_poll_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the block in sleep with its counters cleared. `phase` is 0, and `active`, `path_en` and `chk_start` are all low. The phase codes are sleep = 0, start-up = 1, bit-check = 2 and receiving = 3.
- R2: While `phase` is sleep, `active` and `path_en` are low.
- R3: The sleep phase lasts exactly `sleep_word` × `ext_factor` × 1024 cycles when that product is nonzero. It then moves to start-up.
- R4: When the product in R3 is zero, the sleep phase lasts one cycle. It is never skipped.
- R5: In start-up, `active` and `path_en` are high. Start-up lasts a number of cycles set by `baud_sel`: 96 for 0, 64 for 1, 48 for 2 and 40 for 3. After that it moves to bit-check.
- R6: `chk_start` is high for exactly one cycle, the first cycle of each bit-check phase, and is low at all other times.
- R7: In bit-check, `chk_done` high with `chk_pass` high (and `off_cmd` low) at a clock edge moves the block to receiving at that edge.
- R8: In bit-check, `chk_done` high with `chk_pass` low (and `off_cmd` low) at a clock edge returns the block to sleep at that edge. While `chk_done` is low, the block stays in bit-check.
- R9: Receiving holds, with `active` and `path_en` high, until `off_cmd` is seen. `chk_done` and `chk_pass` have no effect in receiving.
- R10: `off_cmd` high at a clock edge in start-up, bit-check or receiving returns the block to sleep at that edge. It takes priority over `chk_done`. In sleep, `off_cmd` has no effect on the sleep length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Basic clock; one period per polling tick |
| rst | input | 1 | Synchronous reset, active high |
| sleep_word | input | 5 | Sleep multiplier word |
| ext_factor | input | 3 | Sleep extension factor |
| baud_sel | input | 2 | Baud-range selection that indexes the start-up length |
| chk_done | input | 1 | Bit checker has a result |
| chk_pass | input | 1 | Bit checker result; high means valid signal |
| off_cmd | input | 1 | Command to return to sleep |
| phase | output | 2 | Current phase code |
| active | output | 1 | High in every phase other than sleep |
| path_en | output | 1 | Signal-processing enable |
| chk_start | output | 1 | One-cycle strobe that starts the bit checker |

## Verification
The assertions assume that `sleep_word` and `ext_factor` do not change during a sleep interval once counting has passed the first cycle. They also assume the checker raises `chk_done` only during bit-check. The stimulus changes these settings only in the first cycle of a sleep phase, when the counter is still zero. In receiving, it raises `chk_done` only to show that the flag is ignored.

// File: rtl/poll_pkg.sv
package poll_pkg;

    typedef enum logic [1:0] {
        PH_SLEEP   = 2'd0,
        PH_STARTUP = 2'd1,
        PH_CHECK   = 2'd2,
        PH_RECEIVE = 2'd3
    } poll_phase_e;

endpackage

// File: rtl/poll_interval_calc.sv
// Computes the terminal count of the sleep timer from the sleep word and
// the extension factor; a zero product still yields a one-cycle interval.
module poll_interval_calc #(
    parameter int WORD_W = 5,
    parameter int EXT_W  = 3,
    parameter int UNIT   = 1024,
    parameter int CNT_W  = 18
) (
    input  logic [WORD_W-1:0] sleep_word,
    input  logic [EXT_W-1:0]  ext_factor,
    output logic [CNT_W-1:0]  last_count
);
    logic [CNT_W-1:0] product;

    always_comb begin
        product = CNT_W'(sleep_word) * CNT_W'(ext_factor) * CNT_W'(UNIT);
        if (product == '0) begin
            last_count = '0;
        end else begin
            last_count = product - CNT_W'(1);
        end
    end
endmodule

// File: rtl/poll_startup_lut.sv
// Start-up settle lengths, one per baud range, held as terminal counts.
module poll_startup_lut #(
    parameter int CNT_W      = 18,
    parameter int SU_LEN [4] = '{96, 64, 48, 40}
) (
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] last_count
);
    logic [CNT_W-1:0] table_q [4];

    for (genvar g = 0; g < 4; g++) begin : g_entry
        assign table_q[g] = (SU_LEN[g] > 0) ? CNT_W'(SU_LEN[g] - 1) : '0;
    end

    assign last_count = table_q[sel];
endmodule

// File: rtl/rx_poll_seq.sv
module rx_poll_seq #(
    parameter int WORD_W     = 5,
    parameter int EXT_W      = 3,
    parameter int UNIT       = 1024,
    parameter int SU_LEN [4] = '{96, 64, 48, 40}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] sleep_word,
    input  logic [EXT_W-1:0]  ext_factor,
    input  logic [1:0]        baud_sel,
    input  logic              chk_done,
    input  logic              chk_pass,
    input  logic              off_cmd,
    output logic [1:0]        phase,
    output logic              active,
    output logic              path_en,
    output logic              chk_start
);
    import poll_pkg::*;

    localparam int CNT_W = WORD_W + EXT_W + $clog2(UNIT) + 1;

    typedef struct packed {
        poll_phase_e      phase;
        logic [CNT_W-1:0] cnt;
        logic             chk_start;
        logic             active;
        logic             path_en;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [CNT_W-1:0] sleep_last;
    logic [CNT_W-1:0] su_last;

    poll_interval_calc #(
        .WORD_W (WORD_W),
        .EXT_W  (EXT_W),
        .UNIT   (UNIT),
        .CNT_W  (CNT_W)
    ) i_interval (
        .sleep_word (sleep_word),
        .ext_factor (ext_factor),
        .last_count (sleep_last)
    );

    poll_startup_lut #(
        .CNT_W  (CNT_W),
        .SU_LEN (SU_LEN)
    ) i_su_lut (
        .sel        (baud_sel),
        .last_count (su_last)
    );

    always_comb begin
        st_d           = st_q;
        st_d.chk_start = 1'b0;
        case (st_q.phase)
            PH_SLEEP: begin
                if (st_q.cnt >= sleep_last) begin
                    st_d.phase = PH_STARTUP;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_STARTUP: begin
                if (off_cmd) begin
                    st_d.phase = PH_SLEEP;
                    st_d.cnt   = '0;
                end else if (st_q.cnt >= su_last) begin
                    st_d.phase     = PH_CHECK;
                    st_d.cnt       = '0;
                    st_d.chk_start = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_CHECK: begin
                st_d.cnt = '0;
                if (off_cmd) begin
                    st_d.phase = PH_SLEEP;
                end else if (chk_done) begin
                    st_d.phase = chk_pass ? PH_RECEIVE : PH_SLEEP;
                end
            end
            default: begin
                st_d.cnt = '0;
                if (off_cmd) begin
                    st_d.phase = PH_SLEEP;
                end
            end
        endcase
        st_d.active  = (st_d.phase != PH_SLEEP);
        st_d.path_en = (st_d.phase != PH_SLEEP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_SLEEP, cnt: '0, chk_start: 1'b0,
                      active: 1'b0, path_en: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase     = st_q.phase;
    assign active    = st_q.active;
    assign path_en   = st_q.path_en;
    assign chk_start = st_q.chk_start;

    // Sleep may only be left towards start-up.
    p_sleep_exit_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_SLEEP) |=>
            (st_q.phase == PH_SLEEP || st_q.phase == PH_STARTUP));

    p_sleep_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_SLEEP) |-> (st_q.cnt <= sleep_last));

    p_sleep_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0) |-> (!active && !path_en));

    p_wake_startup_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> (st_q.phase == PH_STARTUP));

    p_start_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        chk_start |-> (st_q.phase == PH_CHECK && $past(st_q.phase) == PH_STARTUP));

    p_check_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_CHECK && chk_done && chk_pass && !off_cmd) |=>
            (st_q.phase == PH_RECEIVE));

    p_check_fail_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_CHECK && chk_done && !chk_pass && !off_cmd) |=>
            (st_q.phase == PH_SLEEP));

    p_rx_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_RECEIVE && !off_cmd) |=>
            (st_q.phase == PH_RECEIVE && path_en));

    p_off_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase != PH_SLEEP && off_cmd) |=> (st_q.phase == PH_SLEEP));
endmodule

// File: tb/test_rx_poll_seq.sv
module test_rx_poll_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] sleep_word = 5'd1;
    logic [2:0] ext_factor = 3'd1;
    logic [1:0] baud_sel   = 2'd0;
    logic       chk_done   = 1'b0;
    logic       chk_pass   = 1'b0;
    logic       off_cmd    = 1'b0;
    logic [1:0] phase;
    logic       active, path_en, chk_start;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;
    bit mon_en = 1'b0;

    typedef struct {
        int    ph;
        int    len;
        int    starts;
        string tag;
    } exp_item_t;

    exp_item_t exp_q[$];

    always #2.5 clk = ~clk;

    rx_poll_seq i_rx_poll_seq (
        .clk        (clk),
        .rst        (rst),
        .sleep_word (sleep_word),
        .ext_factor (ext_factor),
        .baud_sel   (baud_sel),
        .chk_done   (chk_done),
        .chk_pass   (chk_pass),
        .off_cmd    (off_cmd),
        .phase      (phase),
        .active     (active),
        .path_en    (path_en),
        .chk_start  (chk_start)
    );

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push(input int ph, input int len, input int starts, input string tag);
        exp_item_t it;
        it.ph = ph; it.len = len; it.starts = starts; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic wait_phase(input int p);
        do @(negedge clk); while (int'(phase) != p);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: measures each phase run and compares it with the scoreboard.
    int  prev_ph = -1;
    int  run_len = 0;
    int  run_starts = 0;
    always @(negedge clk) begin
        if (mon_en) begin
            if (prev_ph >= 0 && int'(phase) != prev_ph) begin
                if (exp_q.size() == 0) begin
                    check_eq("R3", "unexpected phase exit", prev_ph, -1);
                end else begin
                    exp_item_t it;
                    it = exp_q.pop_front();
                    check_eq(it.tag, "phase of run", prev_ph, it.ph);
                    check_eq(it.tag, "run length", run_len, it.len);
                    check_eq("R6", "chk_start pulses in run", run_starts, it.starts);
                end
                // R2 / R5 / R9: activity outputs follow the new phase
                check_eq(int'(phase) == 0 ? "R2" : "R5", "active",
                         int'(active), int'(phase != 2'd0));
                check_eq(int'(phase) == 0 ? "R2" : "R5", "path_en",
                         int'(path_en), int'(phase != 2'd0));
                if (phase == 2'd2) begin
                    check_eq("R6", "chk_start on first check cycle", int'(chk_start), 1);
                end
                run_len = 0;
                run_starts = 0;
            end
            prev_ph = int'(phase);
            run_len++;
            run_starts += int'(chk_start);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL R9 watchdog: actual hung, expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check_eq("R1", "phase in reset", int'(phase), 0);
        check_eq("R1", "active in reset", int'(active), 0);
        check_eq("R1", "path_en in reset", int'(path_en), 0);
        check_eq("R1", "chk_start in reset", int'(chk_start), 0);

        // Scenario 1: R3 sleep 1*1*1024, R5 start-up 96, R7 pass, R9/R10 off in receive
        push(0, 1024, 0, "R3");
        push(1, 96, 0, "R5");
        push(2, 4, 1, "R7");
        push(3, 6, 0, "R9");
        @(posedge clk);
        #1 rst = 1'b0;
        mon_en = 1'b1;
        wait_phase(2);
        repeat (3) @(negedge clk);
        chk_done = 1'b1; chk_pass = 1'b1;
        @(negedge clk);
        chk_done = 1'b0; chk_pass = 1'b0;
        repeat (5) @(negedge clk);
        off_cmd = 1'b1;
        @(negedge clk);
        off_cmd = 1'b0;

        // Scenario 2: R4 zero product gives one sleep cycle, baud 2, R8 fail
        sleep_word = 5'd0; ext_factor = 3'd3; baud_sel = 2'd2;
        push(0, 1, 0, "R4");
        push(1, 48, 0, "R5");
        push(2, 1, 1, "R8");
        wait_phase(2);
        chk_done = 1'b1; chk_pass = 1'b0;
        @(negedge clk);
        chk_done = 1'b0;

        // Scenario 3: R10 off ignored in sleep, off cuts start-up short
        sleep_word = 5'd2; ext_factor = 3'd1; baud_sel = 2'd3;
        push(0, 2048, 0, "R10");
        push(1, 10, 0, "R10");
        repeat (100) @(negedge clk);
        off_cmd = 1'b1;
        repeat (10) @(negedge clk);
        off_cmd = 1'b0;
        wait_phase(1);
        repeat (9) @(negedge clk);
        off_cmd = 1'b1;
        @(negedge clk);
        off_cmd = 1'b0;

        // Scenario 4: R10 off beats a passing result in bit-check
        sleep_word = 5'd3; ext_factor = 3'd1; baud_sel = 2'd1;
        push(0, 3072, 0, "R3");
        push(1, 64, 0, "R5");
        push(2, 2, 1, "R10");
        wait_phase(2);
        @(negedge clk);
        chk_done = 1'b1; chk_pass = 1'b1; off_cmd = 1'b1;
        @(negedge clk);
        chk_done = 1'b0; chk_pass = 1'b0; off_cmd = 1'b0;

        // Scenario 5: R7 immediate pass, R9 done flags ignored in receive
        sleep_word = 5'd1; ext_factor = 3'd1; baud_sel = 2'd0;
        push(0, 1024, 0, "R3");
        push(1, 96, 0, "R5");
        push(2, 1, 1, "R7");
        push(3, 21, 0, "R9");
        wait_phase(2);
        chk_done = 1'b1; chk_pass = 1'b1;
        @(negedge clk);
        chk_done = 1'b0; chk_pass = 1'b0;
        for (int i = 2; i <= 21; i++) begin
            @(negedge clk);
            chk_done = (i == 5);
            off_cmd  = (i == 21);
        end
        @(negedge clk);
        chk_done = 1'b0; off_cmd = 1'b0;
        repeat (5) @(negedge clk);
        check_eq("R10", "phase after final off", int'(phase), 0);
        check_eq("R9", "scoreboard items left", exp_q.size(), 0);
        done_flag = 1'b1;
        finish_run();
    end
endmodule